// File: doc/BRIEF.md
# Serial Memory Block Transfer Sequencer

This block carries out whole block reads and block writes to a serial memory or register device on a two-wire bus. It does not toggle any bus wires. Instead it drives a byte engine through a command port: send a byte (optionally preceded by a START condition), receive a byte (answered with ACK or NACK), or issue a STOP. The engine returns one response for each command. For a send, the response carries the target's acknowledge. For a receive, it carries the received byte.

A host starts a transfer with a single request. The request carries a 7-bit device address, an 8-bit offset, a length, a direction and an addressing mode. Write bytes come in on a valid/ready stream and read bytes go out on another. Each transfer ends with a one-cycle `done` pulse, and `err` qualifies the result. In standard mode the offset is sent as its own byte after the device address. In legacy mode the offset stands in for the device code. Writes are cut into short chunks, and after each chunk the sequencer polls the device until its internal write cycle has finished. Page boundaries are the caller's concern.

Top module: `eeprom_blk_xfer`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `be_cmd_valid`=0, `done`=0, `rd_valid`=0.
- R2: A standard read issues three send commands, in this order:
  - START with the byte {dev,0};
  - the offset, without START and without STOP;
  - after at least GAP_CYCLES idle cycles, START with {dev,1}.
  Command op encoding is 0 = send, 1 = receive, 2 = STOP.
- R3: A read issues `len` receive commands. Every one has the nack flag clear except the last, which has it set. A STOP follows the last receive. The received bytes appear on `rd_data` in order.
- R4: In legacy mode the first byte is {offset[6:0], rw}, sent with START, where rw is 1 for read and 0 for write. No separate offset byte is sent, and a read skips the repeated START.
- R5: A write sends at most CHUNK data bytes after each address phase. The next chunk repeats the address phase with the offset advanced by the number of bytes already written.
- R6: After each write chunk the block issues STOP and then START with {dev,1}. After each NACK it issues STOP and tries again. After an ACK it issues one receive with nack set, then a STOP.
- R7: After POLL_MAX polls have been NACKed (each followed by its STOP), the transfer ends with `err`=1 and issues no further commands.
- R8: A NACK on any address byte, or on a write data byte, causes one STOP, then `done` with `err`=1.
- R9: A request with `len`=0 completes with `done`, `err`=0 and no byte engine command.
- R10: Only one byte engine command is outstanding at a time. Each command stays stable until it is accepted. `rd_valid`/`rd_data` stay stable until `rd_ready`.
- R11: `done` is a single-cycle pulse, and `err` is valid while it is high. The block is ready for a new request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Idle, request accepted |
| req_dev | input | 7 | 7-bit device address |
| req_addr | input | 8 | Starting offset |
| req_len | input | LEN_W | Byte count |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_legacy | input | 1 | Offset-as-device-code mode |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transfer finished (pulse) |
| err | output | 1 | Transfer failed, valid with done |
| be_cmd_valid | output | 1 | Byte engine command valid |
| be_cmd_ready | input | 1 | Byte engine accepts command |
| be_cmd_op | output | 2 | 0 send, 1 receive, 2 STOP |
| be_cmd_start | output | 1 | Precede send with START |
| be_cmd_nack | output | 1 | Answer received byte with NACK |
| be_cmd_data | output | 8 | Byte to send |
| be_rsp_valid | input | 1 | Byte engine response |
| be_rsp_ack | input | 1 | Target acknowledged |
| be_rsp_data | input | 8 | Received byte |

## Verification
A corrupted offset register or chunk counter shows up at the byte engine port on the next address phase: the offset byte is wrong, or a STOP lands in the wrong place in the command log. A miscounted remaining length shows up one command early or late, as a nack flag on the wrong receive or a missing STOP. A stuck poll counter either ends the write with an error too early or never ends it, which the NACK-limit and bounded-wait scenarios expose within a few dozen commands. Every scenario compares the full command log, including each command's position, against a sequence built from the requirements.

// File: rtl/eeprom_blk_xfer.sv
module eeprom_blk_xfer #(
  parameter int LEN_W      = 9,
  parameter int GAP_CYCLES = 15000,
  parameter int POLL_MAX   = 100,
  parameter int CHUNK      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_rd,
  input  logic             req_legacy,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             be_cmd_valid,
  input  logic             be_cmd_ready,
  output logic [1:0]       be_cmd_op,
  output logic             be_cmd_start,
  output logic             be_cmd_nack,
  output logic [7:0]       be_cmd_data,
  input  logic             be_rsp_valid,
  input  logic             be_rsp_ack,
  input  logic [7:0]       be_rsp_data
);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int CW = $clog2(CHUNK + 1);
  localparam logic [1:0] OP_SEND = 2'd0, OP_RECV = 2'd1, OP_STOP = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ADR0, S_ADR1, S_GAP, S_ADR2, S_RD, S_OUT, S_WR,
    S_CSTOP, S_POLL, S_PSTOP, S_DUMMY, S_ESTOP, S_DONE
  } st_t;

  st_t             st;
  logic            pend, rd_m, leg, err_r, issue;
  logic [6:0]      dev;
  logic [7:0]      off, rdat;
  logic [LEN_W-1:0] cnt;
  logic [CW-1:0]   chk;
  logic [GW-1:0]   gap;
  logic [PW-1:0]   poll;

  wire got    = pend && be_rsp_valid;
  wire ok     = be_rsp_ack;
  wire accept = be_cmd_valid && be_cmd_ready;

  always_comb begin
    issue        = 1'b0;
    be_cmd_op    = OP_SEND;
    be_cmd_start = 1'b0;
    be_cmd_nack  = 1'b0;
    be_cmd_data  = 8'h00;
    case (st)
      S_ADR0: begin
        issue = 1'b1; be_cmd_start = 1'b1;
        be_cmd_data = leg ? {off[6:0], rd_m} : {dev, 1'b0};
      end
      S_ADR1: begin issue = 1'b1; be_cmd_data = off; end
      S_ADR2, S_POLL: begin issue = 1'b1; be_cmd_start = 1'b1; be_cmd_data = {dev, 1'b1}; end
      S_RD: begin
        issue = 1'b1; be_cmd_op = OP_RECV;
        be_cmd_nack = (cnt == LEN_W'(1));
      end
      S_DUMMY: begin issue = 1'b1; be_cmd_op = OP_RECV; be_cmd_nack = 1'b1; end
      S_WR: begin issue = wr_valid; be_cmd_data = wr_data; end
      S_CSTOP, S_PSTOP, S_ESTOP: begin issue = 1'b1; be_cmd_op = OP_STOP; end
      default: ;
    endcase
  end

  assign be_cmd_valid = issue && !pend;
  assign wr_ready     = (st == S_WR) && !pend && be_cmd_ready;
  assign req_ready    = (st == S_IDLE);
  assign done         = (st == S_DONE);
  assign err          = err_r;
  assign rd_valid     = (st == S_OUT);
  assign rd_data      = rdat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; err_r <= 1'b0; rd_m <= 1'b0; leg <= 1'b0;
      dev <= '0; off <= '0; cnt <= '0; chk <= '0; gap <= '0; poll <= '0; rdat <= '0;
    end else begin
      if (accept) pend <= 1'b1;
      else if (got) pend <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          dev <= req_dev; off <= req_addr; cnt <= req_len; rd_m <= req_rd;
          leg <= req_legacy; err_r <= 1'b0; chk <= '0;
          st <= (req_len == '0) ? S_DONE : S_ADR0;
        end
        S_ADR0: if (got) begin
          if (!ok) begin err_r <= 1'b1; st <= S_ESTOP; end
          else if (leg) st <= rd_m ? S_RD : S_WR;
          else st <= S_ADR1;
        end
        S_ADR1: if (got) begin
          if (!ok) begin err_r <= 1'b1; st <= S_ESTOP; end
          else if (rd_m) begin gap <= '0; st <= S_GAP; end
          else st <= S_WR;
        end
        S_GAP: begin
          gap <= gap + 1'b1;
          if (gap == GW'(GAP_CYCLES - 1)) st <= S_ADR2;
        end
        S_ADR2: if (got) begin
          if (ok) st <= S_RD;
          else begin err_r <= 1'b1; st <= S_ESTOP; end
        end
        S_RD: if (got) begin rdat <= be_rsp_data; st <= S_OUT; end
        S_OUT: if (rd_ready) begin
          cnt <= cnt - 1'b1;
          st <= (cnt == LEN_W'(1)) ? S_ESTOP : S_RD;
        end
        S_WR: if (got) begin
          if (!ok) begin err_r <= 1'b1; st <= S_ESTOP; end
          else begin
            cnt <= cnt - 1'b1; off <= off + 1'b1; chk <= chk + 1'b1;
            st <= (cnt == LEN_W'(1) || chk == CW'(CHUNK - 1)) ? S_CSTOP : S_WR;
          end
        end
        S_CSTOP: if (got) begin poll <= '0; st <= S_POLL; end
        S_POLL: if (got) begin
          if (ok) st <= S_DUMMY;
          else begin poll <= poll + 1'b1; st <= S_PSTOP; end
        end
        S_PSTOP: if (got) begin
          if (poll == PW'(POLL_MAX)) begin err_r <= 1'b1; st <= S_DONE; end
          else st <= S_POLL;
        end
        S_DUMMY: if (got) st <= S_ESTOP;
        S_ESTOP: if (got) begin
          if (!rd_m && !err_r && cnt != '0) begin chk <= '0; st <= S_ADR0; end
          else st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_blk_xfer_chk.sv
module eeprom_blk_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       be_cmd_valid,
  input logic       be_cmd_ready,
  input logic [1:0] be_cmd_op,
  input logic       be_cmd_start,
  input logic [7:0] be_cmd_data
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R10
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    be_cmd_valid && !be_cmd_ready && be_cmd_op != 2'd0 |=>
      be_cmd_valid && $stable(be_cmd_op) && $stable(be_cmd_data)); // R10
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    be_cmd_valid |-> !req_ready); // R1
  AST_RECV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    be_cmd_valid && be_cmd_op == 2'd1 |-> !be_cmd_start); // R3
endmodule

bind eeprom_blk_xfer eeprom_blk_xfer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
  .be_cmd_valid(be_cmd_valid), .be_cmd_ready(be_cmd_ready),
  .be_cmd_op(be_cmd_op), .be_cmd_start(be_cmd_start), .be_cmd_data(be_cmd_data)
);

// File: tb/eeprom_blk_xfer_tb_top.sv
`timescale 1ns/1ps
module eeprom_blk_xfer_tb_top;
  localparam int GAP = 20;
  localparam int PMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_rd = 1'b0, req_legacy = 1'b0, rd_ready = 1'b1, wr_valid = 1'b1;
  logic [6:0] req_dev = '0;
  logic [7:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic req_ready, wr_ready, rd_valid, done, err;
  logic [7:0] wr_data, rd_data, be_cmd_data;
  logic be_cmd_valid, be_cmd_ready, be_cmd_start, be_cmd_nack;
  logic [1:0] be_cmd_op;
  logic rsp_v, rsp_a;
  logic [7:0] rsp_d;

  eeprom_blk_xfer #(.LEN_W(9), .GAP_CYCLES(GAP), .POLL_MAX(PMAX), .CHUNK(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_addr(req_addr), .req_len(req_len), .req_rd(req_rd),
    .req_legacy(req_legacy), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .err(err),
    .be_cmd_valid(be_cmd_valid), .be_cmd_ready(be_cmd_ready), .be_cmd_op(be_cmd_op),
    .be_cmd_start(be_cmd_start), .be_cmd_nack(be_cmd_nack), .be_cmd_data(be_cmd_data),
    .be_rsp_valid(rsp_v), .be_rsp_ack(rsp_a), .be_rsp_data(rsp_d));

  int tests = 0, fails = 0, cyc = 0;
  int n = 0, base = 0, pidx = 0, dly = 0;
  int nrx = 0, rx_base = 0, widx = 0, w_base = 0;
  logic pend_m = 1'b0;
  logic [63:0] nack_idx = '0;
  logic [11:0] lcmd [64];
  int lt [64];
  logic [7:0] rx [64];

  always @(posedge clk) cyc <= cyc + 1;
  assign be_cmd_ready = !pend_m;
  assign wr_data = 8'h10 + 8'(widx - w_base);

  always @(posedge clk) begin
    if (!rst_n) begin
      pend_m <= 1'b0; rsp_v <= 1'b0; rsp_a <= 1'b0; rsp_d <= '0;
    end else begin
      rsp_v <= 1'b0;
      if (be_cmd_valid && be_cmd_ready) begin
        lcmd[(n - base) & 63] <= {be_cmd_op, be_cmd_start, be_cmd_nack, be_cmd_data};
        lt[(n - base) & 63] <= cyc;
        pidx <= n - base; n <= n + 1; pend_m <= 1'b1; dly <= 2;
      end else if (pend_m) begin
        if (dly == 1) begin
          rsp_v <= 1'b1; rsp_a <= !nack_idx[pidx[5:0]];
          rsp_d <= 8'h50 + pidx[7:0]; pend_m <= 1'b0;
        end
        dly <= dly - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin rx[(nrx - rx_base) & 63] <= rd_data; nrx <= nrx + 1; end
    if (wr_valid && wr_ready) widx <= widx + 1;
  end

  task automatic check(input bit c, input string tag, input int act, input int exp);
    tests++;
    if (!c) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic chkcmd(input int i, input logic [1:0] op, input logic s, input logic k,
                        input logic [7:0] d, input string tag);
    logic [11:0] e;
    e = {op, s, k, d};
    check(lcmd[i] === e, tag, int'(lcmd[i]), int'(e));
  endtask

  task automatic run(input logic [6:0] d, input logic [7:0] a, input int l, input logic r,
                     input logic lg, output logic e);
    int t;
    base = n; rx_base = nrx; w_base = widx;
    @(negedge clk);
    req_dev = d; req_addr = a; req_len = 9'(l); req_rd = r; req_legacy = lg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done === 1'b1, "R11 done seen", int'(done), 1);
    e = err;
    @(negedge clk);
    check(done === 1'b0 && req_ready === 1'b1, "R11 single pulse", int'({done, req_ready}), 1);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1 && be_cmd_valid === 1'b0 && done === 1'b0 && rd_valid === 1'b0,
          "R1 reset state", int'({req_ready, be_cmd_valid, done, rd_valid}), 8);
  endtask

  task automatic t_std_read();
    logic e;
    logic [7:0] d0;
    nack_idx = '0;
    rd_ready = 1'b0;
    fork
      run(7'h50, 8'h3C, 3, 1'b1, 1'b0, e);
      begin
        while (!rd_valid) @(negedge clk);
        d0 = rd_data;
        repeat (5) @(negedge clk);
        check(rd_valid === 1'b1 && rd_data === d0, "R10 read hold", int'(rd_data), int'(d0));
        rd_ready = 1'b1;
      end
    join
    check(e === 1'b0, "R2 err", int'(e), 0);
    check(n - base == 7, "R2 command count", n - base, 7);
    chkcmd(0, 2'd0, 1'b1, 1'b0, 8'hA0, "R2 dev write");
    chkcmd(1, 2'd0, 1'b0, 1'b0, 8'h3C, "R2 offset");
    chkcmd(2, 2'd0, 1'b1, 1'b0, 8'hA1, "R2 repeated start");
    check(lt[2] - lt[1] >= GAP, "R2 gap", lt[2] - lt[1], GAP);
    chkcmd(3, 2'd1, 1'b0, 1'b0, 8'h00, "R3 recv ack");
    chkcmd(4, 2'd1, 1'b0, 1'b0, 8'h00, "R3 recv ack");
    chkcmd(5, 2'd1, 1'b0, 1'b1, 8'h00, "R3 recv last nack");
    chkcmd(6, 2'd2, 1'b0, 1'b0, 8'h00, "R3 stop");
    check(nrx - rx_base == 3, "R3 bytes out", nrx - rx_base, 3);
    for (int i = 0; i < 3; i++)
      check(rx[i] === 8'h53 + 8'(i), "R3 data order", int'(rx[i]), 'h53 + i);
  endtask

  task automatic t_leg_read();
    logic e;
    nack_idx = '0;
    run(7'h50, 8'h25, 2, 1'b1, 1'b1, e);
    check(e === 1'b0 && n - base == 4, "R4 legacy read count", n - base, 4);
    chkcmd(0, 2'd0, 1'b1, 1'b0, 8'h4B, "R4 legacy read byte");
    chkcmd(1, 2'd1, 1'b0, 1'b0, 8'h00, "R4 recv");
    chkcmd(2, 2'd1, 1'b0, 1'b1, 8'h00, "R4 recv last");
    chkcmd(3, 2'd2, 1'b0, 1'b0, 8'h00, "R4 stop");
    check(rx[0] === 8'h51 && rx[1] === 8'h52, "R4 data", int'({rx[0], rx[1]}), 'h5152);
  endtask

  task automatic t_std_write();
    logic e;
    nack_idx = '0;
    run(7'h50, 8'h10, 6, 1'b0, 1'b0, e);
    check(e === 1'b0 && n - base == 18, "R5 write count", n - base, 18);
    check(widx - w_base == 6, "R5 bytes taken", widx - w_base, 6);
    chkcmd(0, 2'd0, 1'b1, 1'b0, 8'hA0, "R5 chunk1 dev");
    chkcmd(1, 2'd0, 1'b0, 1'b0, 8'h10, "R5 chunk1 offset");
    for (int i = 0; i < 4; i++) chkcmd(2 + i, 2'd0, 1'b0, 1'b0, 8'h10 + 8'(i), "R5 chunk1 data");
    chkcmd(6, 2'd2, 1'b0, 1'b0, 8'h00, "R6 chunk stop");
    chkcmd(7, 2'd0, 1'b1, 1'b0, 8'hA1, "R6 poll");
    chkcmd(8, 2'd1, 1'b0, 1'b1, 8'h00, "R6 dummy read");
    chkcmd(9, 2'd2, 1'b0, 1'b0, 8'h00, "R6 dummy stop");
    chkcmd(10, 2'd0, 1'b1, 1'b0, 8'hA0, "R5 chunk2 dev");
    chkcmd(11, 2'd0, 1'b0, 1'b0, 8'h14, "R5 chunk2 offset advanced");
    chkcmd(12, 2'd0, 1'b0, 1'b0, 8'h14, "R5 chunk2 data");
    chkcmd(13, 2'd0, 1'b0, 1'b0, 8'h15, "R5 chunk2 data");
    chkcmd(14, 2'd2, 1'b0, 1'b0, 8'h00, "R6 chunk2 stop");
    chkcmd(15, 2'd0, 1'b1, 1'b0, 8'hA1, "R6 chunk2 poll");
    chkcmd(17, 2'd2, 1'b0, 1'b0, 8'h00, "R6 final stop");
  endtask

  task automatic t_leg_write_poll();
    logic e;
    nack_idx = '0; nack_idx[4] = 1'b1; nack_idx[6] = 1'b1;
    run(7'h50, 8'h7F, 2, 1'b0, 1'b1, e);
    check(e === 1'b0 && n - base == 11, "R6 poll retry count", n - base, 11);
    chkcmd(0, 2'd0, 1'b1, 1'b0, 8'hFE, "R4 legacy write byte");
    chkcmd(1, 2'd0, 1'b0, 1'b0, 8'h10, "R4 legacy data");
    chkcmd(3, 2'd2, 1'b0, 1'b0, 8'h00, "R6 stop");
    chkcmd(4, 2'd0, 1'b1, 1'b0, 8'hA1, "R6 poll1");
    chkcmd(5, 2'd2, 1'b0, 1'b0, 8'h00, "R6 stop after nack");
    chkcmd(8, 2'd0, 1'b1, 1'b0, 8'hA1, "R6 poll3");
    chkcmd(9, 2'd1, 1'b0, 1'b1, 8'h00, "R6 dummy read");
  endtask

  task automatic t_poll_limit();
    logic e;
    nack_idx = ~64'hF;
    run(7'h50, 8'h00, 1, 1'b0, 1'b0, e);
    check(e === 1'b1, "R7 poll limit err", int'(e), 1);
    check(n - base == 10, "R7 command count", n - base, 10);
    chkcmd(9, 2'd2, 1'b0, 1'b0, 8'h00, "R7 last stop");
    repeat (10) @(negedge clk);
    check(n - base == 10, "R7 no more commands", n - base, 10);
  endtask

  task automatic t_nacks();
    logic e;
    nack_idx = 64'h1;
    run(7'h50, 8'h00, 2, 1'b1, 1'b0, e);
    check(e === 1'b1 && n - base == 2, "R8 dev nack", n - base, 2);
    chkcmd(1, 2'd2, 1'b0, 1'b0, 8'h00, "R8 stop after dev nack");
    nack_idx = 64'h2;
    run(7'h50, 8'h40, 2, 1'b1, 1'b0, e);
    check(e === 1'b1 && n - base == 3, "R8 offset nack", n - base, 3);
    check(nrx - rx_base == 0, "R8 no read data", nrx - rx_base, 0);
    nack_idx = 64'h4;
    run(7'h50, 8'h40, 3, 1'b0, 1'b0, e);
    check(e === 1'b1 && n - base == 4, "R8 data nack", n - base, 4);
    chkcmd(3, 2'd2, 1'b0, 1'b0, 8'h00, "R8 stop after data nack");
    check(widx - w_base == 1, "R8 bytes taken", widx - w_base, 1);
  endtask

  task automatic t_zero_len();
    logic e;
    nack_idx = '0;
    run(7'h50, 8'h00, 0, 1'b1, 1'b0, e);
    check(e === 1'b0 && n - base == 0, "R9 zero length", n - base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std_read();
    t_leg_read();
    t_std_write();
    t_leg_write_poll();
    t_poll_limit();
    t_nacks();
    t_zero_len();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule